// File: doc/BRIEF.md
# Serial FPGA Configuration Loader

This block loads a configuration image into a downstream FPGA that accepts its image over a serial peripheral port. On a start pulse it selects the target, pulses the target's active-low reset, and checks that the target has not already come up. It then waits for the target to clear its configuration memory and shifts the image bytes out, most significant bit first, on a divided serial clock. Throughout the load it watches the target's done input.

Image bytes come in on a valid/ready byte stream. The length of the image is taken from an input when the start pulse arrives. If the image runs out before done rises, the block sends zero bytes up to a bounded count. Once done is high it sends a fixed number of zero bytes as extra clocks and then deselects the target. The load ends with a one-cycle completion pulse, a 2-bit result code and the number of image bytes actually consumed.

All timing is derived from parameters: the clock frequency in MHz, the minimum reset width in ns, the memory-clear wait in µs, and the serial clock half-period in system clocks.

Top module: `cfgLoader`

## Requirements
- R1: While idle, cfgCsN=1, cfgRstN=1, cfgSck=0, byteReady=0 and busy=0. The byte stream is ignored and bytesUsed keeps its value. A start pulse that arrives while busy=1 has no effect.
- R2: After a start, cfgCsN goes low one cycle before cfgRstN goes low, and cfgCsN stays low for as long as cfgRstN is low.
- R3: cfgRstN stays low for exactly ceil(RST_NS*CLK_MHZ/1000) clock cycles (25 at 125 MHz and 200 ns).
- R4: cfgDone is sampled in the first cycle after cfgRstN rises. If it is high, the block does the following and sends no serial clock at all:
  - raises cfgCsN;
  - pulses donePulse;
  - reports status 2'b01 (start error).
- R5: The first rising cfgSck edge comes no earlier than WAIT_US*CLK_MHZ clock cycles after cfgRstN rises.
- R6: Each byte is shifted out MSB first. cfgMosi changes only while cfgSck is low, so it is stable across every rising edge. Each half-period of cfgSck is SCK_DIV clocks.
- R7: Image bytes are sent in arrival order, and each one is taken with a byteValid&&byteReady handshake. cfgDone is checked before each byte, and once it is high no further image byte is taken. bytesUsed counts the bytes taken and never exceeds the latched length.
- R8: If every image byte has been sent and cfgDone is still low, zero bytes are sent, up to PAD_BYTES of them. cfgDone is checked before each zero byte.
- R9: If cfgDone is still low after PAD_BYTES zero bytes, the block raises cfgCsN, pulses donePulse and reports status 2'b10 (configuration error).
- R10: After cfgDone is seen high, exactly DUMMY_BYTES zero bytes are sent (8*DUMMY_BYTES rising edges, at least 49). Then cfgCsN rises, donePulse pulses and status is 2'b00 (ok).
- R11: donePulse is high for one cycle, and busy is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset of the block |
| startPulse | input | 1 | One-cycle request to begin a load |
| totalLen | input | LEN_W | Image length in bytes, latched at start |
| byteData | input | 8 | Image byte |
| byteValid | input | 1 | byteData holds a byte |
| byteReady | output | 1 | The block takes the byte in this cycle |
| cfgCsN | output | 1 | Target chip select, active low |
| cfgRstN | output | 1 | Target reset, active low |
| cfgSck | output | 1 | Serial clock to the target |
| cfgMosi | output | 1 | Serial data to the target |
| cfgDone | input | 1 | Target done indication |
| busy | output | 1 | A load is in progress |
| donePulse | output | 1 | One-cycle pulse at the end of a load |
| status | output | 2 | 00 ok, 01 start error, 10 configuration error |
| bytesUsed | output | LEN_W | Image bytes consumed by the last load |

## Verification
A control state stuck or skipped shows up at once as a wrong chip select or reset level, or as a reset pulse whose width differs from the computed count. A wrong byte or pad counter shows up differently: the total number of rising serial-clock edges, or the bytesUsed value, is wrong when donePulse fires. Shifter faults corrupt the byte that the bench-side target model assembles on the rising edges. The scoreboard reports such a fault within the eight edges of the affected byte. A wrong exit path is visible at the completion pulse through the status code.

// File: rtl/cfgLoadPkg.sv
package cfgLoadPkg;
  typedef enum logic [1:0] {
    RES_OK        = 2'd0,
    RES_START_ERR = 2'd1,
    RES_CFG_ERR   = 2'd2
  } cfgResult_e;

  // Strobe from control to the serial datapath
  typedef struct packed {
    logic       load;
    logic [7:0] data;
  } shiftCmd_t;
endpackage

// File: rtl/cfgShift.sv
module cfgShift
  import cfgLoadPkg::*;
#(
  parameter int SCK_DIV = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  shiftCmd_t cmd,
  output logic      sck,
  output logic      mosi,
  output logic      idle
);
  localparam int DIV_W = $clog2(SCK_DIV + 1);

  logic             active;
  logic [7:0]       shReg;
  logic [2:0]       bitCnt;
  logic [DIV_W-1:0] divCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      sck    <= 1'b0;
      shReg  <= '0;
      bitCnt <= '0;
      divCnt <= '0;
    end else if (cmd.load && !active) begin
      active <= 1'b1;
      sck    <= 1'b0;
      shReg  <= cmd.data;
      bitCnt <= '0;
      divCnt <= DIV_W'(SCK_DIV - 1);
    end else if (active) begin
      if (divCnt != '0) begin
        divCnt <= divCnt - 1'b1;
      end else begin
        divCnt <= DIV_W'(SCK_DIV - 1);
        if (!sck) begin
          sck <= 1'b1;
        end else begin
          // falling edge: the next bit is presented while sck is low
          sck <= 1'b0;
          if (bitCnt == 3'd7) begin
            active <= 1'b0;
            shReg  <= '0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
            shReg  <= {shReg[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign mosi = shReg[7];
  assign idle = !active;

  assert_load_when_idle_R6 : assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |-> !active);
  assert_mosi_stable_high_R6 : assert property (@(posedge clk) disable iff (!rstN)
    (sck && $past(sck)) |-> $stable(mosi));
endmodule

// File: rtl/cfgCtrl.sv
module cfgCtrl
  import cfgLoadPkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int RST_CYC     = 25,
  parameter int WAIT_CYC    = 37500,
  parameter int PAD_BYTES   = 128,
  parameter int DUMMY_BYTES = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [LEN_W-1:0] totalLen,
  input  logic [7:0]       byteData,
  input  logic             byteValid,
  output logic             byteReady,
  input  logic             cfgDone,
  input  logic             shIdle,
  output shiftCmd_t        cmd,
  output logic             csN,
  output logic             tgtRstN,
  output logic             busy,
  output logic             donePulse,
  output logic [1:0]       status,
  output logic [LEN_W-1:0] bytesUsed
);
  localparam int MAX_A = (RST_CYC > WAIT_CYC) ? RST_CYC : WAIT_CYC;
  localparam int MAX_B = (PAD_BYTES > DUMMY_BYTES) ? PAD_BYTES : DUMMY_BYTES;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_C + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_SEL, S_RST, S_CHK, S_WAIT, S_STREAM, S_PAD, S_DUMMY, S_END
  } state_e;

  state_e           state;
  logic [CNT_W-1:0] cnt;
  logic [LEN_W-1:0] lenQ;
  cfgResult_e       resQ;

  always_comb begin
    byteReady = (state == S_STREAM) && shIdle && !cfgDone && (bytesUsed != lenQ);
    cmd       = '0;
    unique case (state)
      S_STREAM: if (byteValid && byteReady) begin
        cmd.load = 1'b1;
        cmd.data = byteData;
      end
      S_PAD:   cmd.load = shIdle && !cfgDone && (cnt < CNT_W'(PAD_BYTES));
      S_DUMMY: cmd.load = shIdle && (cnt < CNT_W'(DUMMY_BYTES));
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      cnt       <= '0;
      lenQ      <= '0;
      bytesUsed <= '0;
      resQ      <= RES_OK;
    end else begin
      unique case (state)
        S_IDLE: if (startPulse) begin
          state     <= S_SEL;
          lenQ      <= totalLen;
          bytesUsed <= '0;
          resQ      <= RES_OK;
        end
        S_SEL: begin
          state <= S_RST;
          cnt   <= '0;
        end
        S_RST:
          if (cnt == CNT_W'(RST_CYC - 1)) state <= S_CHK;
          else cnt <= cnt + 1'b1;
        S_CHK:
          if (cfgDone) begin
            state <= S_END;
            resQ  <= RES_START_ERR;
          end else begin
            state <= S_WAIT;
            cnt   <= '0;
          end
        S_WAIT:
          if (cnt == CNT_W'(WAIT_CYC - 1)) state <= S_STREAM;
          else cnt <= cnt + 1'b1;
        S_STREAM: if (shIdle) begin
          if (cfgDone) begin
            state <= S_DUMMY;
            cnt   <= '0;
          end else if (bytesUsed == lenQ) begin
            state <= S_PAD;
            cnt   <= '0;
          end else if (byteValid) begin
            bytesUsed <= bytesUsed + 1'b1;
          end
        end
        S_PAD: if (shIdle) begin
          if (cfgDone) begin
            state <= S_DUMMY;
            cnt   <= '0;
          end else if (cnt == CNT_W'(PAD_BYTES)) begin
            state <= S_END;
            resQ  <= RES_CFG_ERR;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DUMMY: if (shIdle) begin
          if (cnt == CNT_W'(DUMMY_BYTES)) state <= S_END;
          else cnt <= cnt + 1'b1;
        end
        S_END:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign csN       = (state == S_IDLE) || (state == S_END);
  assign tgtRstN   = (state != S_RST);
  assign busy      = (state != S_IDLE);
  assign donePulse = (state == S_END);
  assign status    = resQ;

  assert_cs_low_in_reset_R2 : assert property (@(posedge clk) disable iff (!rstN)
    !tgtRstN |-> !csN);
  assert_used_within_len_R7 : assert property (@(posedge clk) disable iff (!rstN)
    bytesUsed <= lenQ);
  assert_single_pulse_R11 : assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> (!donePulse && !busy));
  assert_no_take_when_done_R7 : assert property (@(posedge clk) disable iff (!rstN)
    cfgDone |-> !byteReady);
endmodule

// File: rtl/cfgLoader.sv
module cfgLoader
  import cfgLoadPkg::*;
#(
  parameter int CLK_MHZ     = 125,
  parameter int RST_NS      = 200,
  parameter int WAIT_US     = 300,
  parameter int SCK_DIV     = 2,
  parameter int PAD_BYTES   = 128,
  parameter int DUMMY_BYTES = 7,
  parameter int LEN_W       = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [LEN_W-1:0] totalLen,
  input  logic [7:0]       byteData,
  input  logic             byteValid,
  output logic             byteReady,
  output logic             cfgCsN,
  output logic             cfgRstN,
  output logic             cfgSck,
  output logic             cfgMosi,
  input  logic             cfgDone,
  output logic             busy,
  output logic             donePulse,
  output logic [1:0]       status,
  output logic [LEN_W-1:0] bytesUsed
);
  // waits rounded up to whole cycles
  localparam int RST_CYC  = (RST_NS * CLK_MHZ + 999) / 1000;
  localparam int WAIT_CYC = WAIT_US * CLK_MHZ;

  shiftCmd_t cmd;
  logic      shIdle;

  cfgCtrl #(
    .LEN_W(LEN_W), .RST_CYC(RST_CYC), .WAIT_CYC(WAIT_CYC),
    .PAD_BYTES(PAD_BYTES), .DUMMY_BYTES(DUMMY_BYTES)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .totalLen(totalLen),
    .byteData(byteData), .byteValid(byteValid), .byteReady(byteReady),
    .cfgDone(cfgDone), .shIdle(shIdle), .cmd(cmd), .csN(cfgCsN),
    .tgtRstN(cfgRstN), .busy(busy), .donePulse(donePulse),
    .status(status), .bytesUsed(bytesUsed)
  );

  cfgShift #(.SCK_DIV(SCK_DIV)) i_shift (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .sck(cfgSck), .mosi(cfgMosi), .idle(shIdle)
  );

  assert_sck_low_deselected_R1 : assert property (@(posedge clk) disable iff (!rstN)
    cfgCsN |-> !cfgSck);
endmodule

// File: tb/test_cfgLoader.sv
module test_cfgLoader;
  localparam int LEN_W = 16, PAD = 128, DUMMY = 7, WAIT_US = 4, MHZ = 125;
  localparam int RST_EXP = 25, WAIT_EXP = WAIT_US * MHZ;

  logic clk = 0, rstN = 0, startPulse = 0, byteValid = 0, cfgDone = 0;
  logic [LEN_W-1:0] totalLen = '0;
  logic [7:0] byteData = '0;
  logic byteReady, cfgCsN, cfgRstN, cfgSck, cfgMosi, busy, donePulse;
  logic [1:0] status;
  logic [LEN_W-1:0] bytesUsed;

  cfgLoader #(.CLK_MHZ(MHZ), .WAIT_US(WAIT_US), .PAD_BYTES(PAD), .DUMMY_BYTES(DUMMY),
              .LEN_W(LEN_W)) i_cfgLoader (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .totalLen(totalLen),
    .byteData(byteData), .byteValid(byteValid), .byteReady(byteReady),
    .cfgCsN(cfgCsN), .cfgRstN(cfgRstN), .cfgSck(cfgSck), .cfgMosi(cfgMosi),
    .cfgDone(cfgDone), .busy(busy), .donePulse(donePulse), .status(status),
    .bytesUsed(bytesUsed));

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] expQ[$];
  logic [7:0] img[0:63];
  int feedIdx = 0, feedN = 0;
  int riseCnt = 0, doneAfter = 0, rstLow = 0, mosiMoves = 0, sckOutside = 0;
  int rstRiseCyc = -1, firstRise = -1, csOrderOk = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial forever @(posedge clk) cyc++;

  initial begin : watchdog
    wait (cyc > 150000);
    check(0, "watchdog", "run hung", cyc, 150000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  // driver: offers image bytes, always keeps byteValid high
  initial forever begin
    @(negedge clk); #1;
    byteValid = 1'b1;
    byteData  = (feedIdx < feedN) ? img[feedIdx] : 8'hEE;
    if (byteReady) begin
      @(posedge clk);
      feedIdx++;
    end
  end

  // monitor: target model and scoreboard
  initial begin : monitor
    logic pSck, pRst, pCs, pMosi;
    logic [7:0] shByte;
    int bitN;
    pSck = 0; pRst = 1; pCs = 1; pMosi = 0; shByte = 0; bitN = 0;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (!cfgRstN) rstLow++;
        if (!cfgRstN && pRst) csOrderOk = (!pCs && !cfgCsN) ? 1 : 0;
        if (cfgRstN && !pRst) rstRiseCyc = cyc;
        if (cfgSck && pSck && cfgMosi != pMosi) mosiMoves++;
        if (cfgSck && !pSck) begin
          if (firstRise < 0) firstRise = cyc;
          if (cfgCsN) sckOutside++;
          riseCnt++;
          shByte = {shByte[6:0], cfgMosi};
          bitN++;
          if (bitN == 8) begin
            bitN = 0;
            if (expQ.size() == 0) check(0, "R7", "unexpected byte", shByte, -1);
            else begin
              logic [7:0] e;
              e = expQ.pop_front();
              check(shByte == e, "R6/R7/R8", "serial byte", shByte, e);
            end
          end
          if (doneAfter > 0 && riseCnt == doneAfter) cfgDone = 1'b1;
        end
      end
      pSck = cfgSck; pRst = cfgRstN; pCs = cfgCsN; pMosi = cfgMosi;
    end
  end

  // driver task: builds the expected stream, starts the load, checks the end
  task automatic runCase(string name, int len, int doneByte, bit preDone, bit poke);
    int sent, pads, expStat, expRises;
    expQ.delete();
    riseCnt = 0; rstLow = 0; mosiMoves = 0; sckOutside = 0;
    rstRiseCyc = -1; firstRise = -1; csOrderOk = 0;
    for (int i = 0; i < 64; i++) img[i] = 8'(8'h5A ^ (i * 37));
    feedIdx = 0; feedN = len;
    cfgDone = preDone;
    doneAfter = doneByte * 8;
    if (preDone) begin
      sent = 0; pads = 0; expStat = 1; expRises = 0;
    end else if (doneByte == 0) begin
      sent = len; pads = PAD; expStat = 2;
    end else begin
      sent = (doneByte < len) ? doneByte : len;
      pads = doneByte - sent; expStat = 0;
    end
    for (int i = 0; i < sent; i++) expQ.push_back(img[i]);
    for (int i = 0; i < pads; i++) expQ.push_back(8'h00);
    if (!preDone && doneByte != 0) for (int i = 0; i < DUMMY; i++) expQ.push_back(8'h00);
    if (!preDone) expRises = 8 * expQ.size();

    @(negedge clk);
    totalLen = LEN_W'(len); startPulse = 1;
    @(negedge clk);
    startPulse = 0; totalLen = '0;
    if (poke) begin
      repeat (700) @(negedge clk);
      startPulse = 1;  // ignored while busy (R1)
      @(negedge clk);
      startPulse = 0;
    end
    while (!donePulse) @(negedge clk);
    check(status == 2'(expStat), "R4/R9/R10", {name, " status"}, status, expStat);
    check(cfgCsN == 1'b1, "R9/R10", {name, " cs raised at end"}, cfgCsN, 1);
    check(bytesUsed == LEN_W'(sent), "R7", {name, " bytesUsed"}, bytesUsed, sent);
    @(negedge clk);
    check(!busy && !donePulse, "R11", {name, " pulse width / busy"}, busy, 0);
    repeat (4) @(negedge clk);
    check(feedIdx == sent, "R7", {name, " bytes taken"}, feedIdx, sent);
    check(riseCnt == expRises, "R8/R10", {name, " rising edges"}, riseCnt, expRises);
    check(expQ.size() == 0, "R7", {name, " bytes missing"}, expQ.size(), 0);
    check(mosiMoves == 0, "R6", {name, " mosi moved while sck high"}, mosiMoves, 0);
    check(sckOutside == 0, "R1", {name, " sck while deselected"}, sckOutside, 0);
    check(rstLow == RST_EXP, "R3", {name, " reset width"}, rstLow, RST_EXP);
    check(csOrderOk == 1, "R2", {name, " cs before reset"}, csOrderOk, 1);
    if (preDone) check(firstRise < 0, "R4", {name, " no clock on start error"}, firstRise, -1);
    else check(firstRise - rstRiseCyc >= WAIT_EXP, "R5", {name, " clear wait"},
               firstRise - rstRiseCyc, WAIT_EXP);
    cfgDone = 0; doneAfter = 0;
  endtask

  task automatic idleCheck(int expUsed);
    int taken;
    taken = feedIdx;
    repeat (20) @(negedge clk);
    check(cfgCsN && cfgRstN && !cfgSck, "R1", "idle pins", {cfgCsN, cfgRstN, cfgSck}, 3'b110);
    check(!byteReady && !busy, "R1", "idle ready/busy", {byteReady, busy}, 0);
    check(bytesUsed == LEN_W'(expUsed), "R1", "bytesUsed held", bytesUsed, expUsed);
    check(feedIdx == taken, "R1", "stream ignored", feedIdx, taken);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(cfgCsN && cfgRstN && !cfgSck && !busy && status == 2'b00, "R1", "reset state",
          {cfgCsN, cfgRstN, cfgSck, busy}, 4'b1100);
    rstN = 1;
    idleCheck(0);
    runCase("normal", 5, 5, 0, 1);
    idleCheck(5);
    runCase("start error", 4, 0, 1, 0);
    runCase("early done", 6, 3, 0, 0);
    runCase("padded", 2, 5, 0, 0);
    runCase("zero length", 0, 2, 0, 0);
    runCase("config error", 1, 0, 0, 0);
    idleCheck(1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule